// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block paces the frames of a full-speed USB host controller. Software programs a frame interval in bit times, a per-frame packet limit and a toggle flag through a small register port. A 14-bit down counter tracks the bit times left in the current frame and steps once per bit-time tick. When it has reached zero, the next tick reloads it from the programmed interval, raises a one-clock start-of-frame strobe, advances a 16-bit frame number and refills a packet budget counter from the programmed limit.

The budget counter steps down on a bit-transfer strobe and stops at zero. Its zero flag tells a scheduler that no further transaction fits in the rest of the frame. A new interval written in the middle of a frame does not disturb the count that is running. It is used at the next reload, so software can trim the frame length without glitching the current frame.

Top module: `usb_frame_timer`

## Requirements
- R1: After a synchronous active-low reset, the interval register (select 0) reads 0x00002EDF (interval 11999, limit 0, toggle 0), the remaining register (select 1) reads 0, the frame number and the packet budget are 0, the budget-empty flag is 1, and the SOF strobe is 0.
- R2: A write to select 0 stores bit 31 as the toggle flag, bits 30:16 as the 15-bit packet limit and bits 13:0 as the interval. Bits 15:14 always read 0, whatever was written to them.
- R3: The remaining register reads the frame toggle in bit 31 and the count in bits 13:0, with bits 30:14 reading 0. Writes to select 1 are ignored.
- R4: A clock with `bit_tick` high and a nonzero count lowers the count by exactly one. Without `bit_tick`, the count holds.
- R5: A clock with `bit_tick` high while the count is 0 loads the interval into the count, and `sof_pulse` is high for the single clock after that edge.
- R6: Consecutive SOF strobes are separated by interval+1 bit-time ticks.
- R7: At each reload, bit 31 of the remaining register takes the toggle flag then held in the interval register.
- R8: The frame number rises by one with each SOF strobe and wraps from 0xFFFF to 0.
- R9: At each SOF, the packet budget is loaded with the programmed limit.
- R10: Each clock with `bit_xfer` high lowers a nonzero budget by one. A zero budget stays at zero, and `pkt_budget_empty` is high exactly when the budget is zero.
- R11: An interval written mid-frame leaves the running count unchanged and is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 interval, 1 remaining |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| bit_tick | input | 1 | One full-speed bit time has elapsed |
| bit_xfer | input | 1 | One bit of packet data moved |
| sof_pulse | output | 1 | Start-of-frame strobe, one clock |
| frame_num | output | 16 | Frame number |
| pkt_budget | output | 15 | Bits of packet data still allowed this frame |
| pkt_budget_empty | output | 1 | Budget exhausted |

## Verification
A wrong count shows at the remaining register on the next read, and it also shifts the next SOF strobe away from the interval+1 tick spacing. A missed or doubled reload shows within one frame as a wrong frame number and a budget that is not refilled. A toggle or interval taken from the wrong moment shows in the remaining register right after the reload it corrupts. The frame-number wrap and the budget saturation are driven to their limits so that an off-by-one error appears at the first cycle past the limit.

// File: rtl/frm_timer_pkg.sv
// Package: register layout and shared types of the frame interval timer.
// Assumes a 32-bit register port; field positions are fixed by the layout.
package frm_timer_pkg;
    localparam int REG_W  = 32;
    localparam int IVL_W  = 14;
    localparam int LIM_W  = 15;
    localparam int RSV_W  = REG_W - 1 - LIM_W - IVL_W;   // gap between interval and limit
    localparam int LIM_LO = IVL_W + RSV_W;                // limit field low bit
    localparam int TOG_B  = REG_W - 1;                    // toggle bit position
    localparam int REM_PAD_W = REG_W - 1 - IVL_W;         // zero pad in remaining reg

    typedef enum logic {
        SEL_IVL = 1'b0,
        SEL_REM = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             toggle;
        logic [LIM_W-1:0] limit;
        logic [IVL_W-1:0] ivl;
    } ivl_cfg_t;
endpackage

// File: rtl/frm_cfg_regs.sv
// Module: holds the software-written interval, packet limit and toggle.
// Assumes writes are single-cycle strobes; reserved bits are dropped on write.
module frm_cfg_regs
    import frm_timer_pkg::*;
#(
    parameter int unsigned NOMINAL_IVL = 11999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  reg_sel_e         wr_sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output ivl_cfg_t         cfg_o
);
    ivl_cfg_t cfg_q;

    // Capture interval-register writes; remaining-register writes never land here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.toggle <= 1'b0;
            cfg_q.limit  <= '0;
            cfg_q.ivl    <= IVL_W'(NOMINAL_IVL);
        end else if (wr_en_i && (wr_sel_i == SEL_IVL)) begin
            cfg_q.toggle <= wdata_i[TOG_B];
            cfg_q.limit  <= wdata_i[LIM_LO +: LIM_W];
            cfg_q.ivl    <= wdata_i[IVL_W-1:0];
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == SEL_IVL) |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/frm_countdown.sv
// Module: bit-time down counter of the current frame with reload and SOF.
// Assumes tick_i is a one-clock strobe per bit time; reload happens on the
// tick that finds the count at zero, using the interval held at that edge.
module frm_countdown
    import frm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic             toggle_i,
    output logic [IVL_W-1:0] rem_o,
    output logic             rem_tog_o,
    output logic             reload_o,
    output logic             sof_o
);
    logic [IVL_W-1:0] rem_q;
    logic             tog_q;
    logic             sof_q;
    logic             at_zero;

    // Detect the tick that ends the frame.
    always_comb begin
        at_zero  = (rem_q == '0);
        reload_o = tick_i && at_zero;
    end

    // Count down per tick, or reload and latch the toggle at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            tog_q <= 1'b0;
        end else if (reload_o) begin
            rem_q <= ivl_i;
            tog_q <= toggle_i;
        end else if (tick_i) begin
            rem_q <= rem_q - IVL_W'(1);
        end
    end

    // Register the start-of-frame strobe for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sof_q <= 1'b0;
        else        sof_q <= reload_o;
    end

    assign rem_o     = rem_q;
    assign rem_tog_o = tog_q;
    assign sof_o     = sof_q;

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && rem_q != '0) |=> (rem_q == $past(rem_q) - IVL_W'(1)) && !sof_q); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(rem_q) && !sof_q); // R4
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_q |-> (rem_q == $past(ivl_i)) && (tog_q == $past(toggle_i))); // R5
endmodule

// File: rtl/frm_number.sv
// Module: wrapping frame number, advanced once per frame start.
// Assumes adv_i is high for one clock per frame boundary.
module frm_number #(
    parameter int unsigned FNUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [FNUM_W-1:0] fnum_o
);
    logic [FNUM_W-1:0] fnum_q;

    // Advance the frame number; natural overflow gives the wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     fnum_q <= '0;
        else if (adv_i) fnum_q <= fnum_q + FNUM_W'(1);
    end

    assign fnum_o = fnum_q;

    AST_FNUM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(fnum_q)); // R8
endmodule

// File: rtl/pkt_budget.sv
// Module: per-frame largest-packet budget, refilled at each frame start.
// Assumes xfer_i is one strobe per bit moved; a refill wins over a step.
module pkt_budget
    import frm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             xfer_i,
    output logic [LIM_W-1:0] budget_o,
    output logic             empty_o
);
    logic [LIM_W-1:0] bud_q;
    logic             bud_zero;

    // Flag an exhausted budget.
    always_comb bud_zero = (bud_q == '0);

    // Refill at frame start, otherwise step down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  bud_q <= '0;
        else if (load_i)             bud_q <= limit_i;
        else if (xfer_i && !bud_zero) bud_q <= bud_q - LIM_W'(1);
    end

    assign budget_o = bud_q;
    assign empty_o  = bud_zero;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && bud_q == '0) |=> bud_q == '0); // R10
    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> bud_q == $past(limit_i)); // R9
endmodule

// File: rtl/usb_frame_timer.sv
// Module: top of the full-speed frame interval timer. Ties the config
// register, frame countdown, frame number and packet budget together and
// serves the combinational register readback.
// Assumes a single clock domain and one register access per clock.
module usb_frame_timer
    import frm_timer_pkg::*;
#(
    parameter int unsigned NOMINAL_IVL = 11999,
    parameter int unsigned FNUM_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bit_tick,
    input  logic              bit_xfer,
    output logic              sof_pulse,
    output logic [FNUM_W-1:0] frame_num,
    output logic [LIM_W-1:0]  pkt_budget,
    output logic              pkt_budget_empty
);
    reg_sel_e         sel;
    ivl_cfg_t         cfg;
    logic [IVL_W-1:0] rem;
    logic             rem_tog;
    logic             reload;

    assign sel = reg_sel_e'(reg_sel);

    frm_cfg_regs #(.NOMINAL_IVL(NOMINAL_IVL)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr_en),
        .wr_sel_i (sel),
        .wdata_i  (reg_wdata),
        .cfg_o    (cfg)
    );

    frm_countdown u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (bit_tick),
        .ivl_i     (cfg.ivl),
        .toggle_i  (cfg.toggle),
        .rem_o     (rem),
        .rem_tog_o (rem_tog),
        .reload_o  (reload),
        .sof_o     (sof_pulse)
    );

    frm_number #(.FNUM_W(FNUM_W)) u_fnum (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (reload),
        .fnum_o (frame_num)
    );

    pkt_budget u_bud (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (reload),
        .limit_i  (cfg.limit),
        .xfer_i   (bit_xfer),
        .budget_o (pkt_budget),
        .empty_o  (pkt_budget_empty)
    );

    // Read mux: reserved and pad bits always return zero.
    always_comb begin
        unique case (sel)
            SEL_IVL: reg_rdata = {cfg.toggle, cfg.limit, {RSV_W{1'b0}}, cfg.ivl};
            SEL_REM: reg_rdata = {rem_tog, {REM_PAD_W{1'b0}}, rem};
            default: reg_rdata = '0;
        endcase
    end

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> frame_num == FNUM_W'($past(frame_num) + 1'b1)); // R8
    AST_SOF_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> pkt_budget == $past(cfg.limit)); // R9
endmodule

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_tick = 1'b0;
    logic        bit_xfer = 1'b0;
    logic        sof_pulse;
    logic [15:0] frame_num;
    logic [14:0] pkt_budget;
    logic        pkt_budget_empty;

    int checks = 0;
    int fails  = 0;

    usb_frame_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
        .bit_xfer(bit_xfer), .sof_pulse(sof_pulse), .frame_num(frame_num),
        .pkt_budget(pkt_budget), .pkt_budget_empty(pkt_budget_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] data);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic tick_once();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 0;
    endtask

    task automatic xfer_once();
        @(negedge clk); bit_xfer = 1'b1;
        @(negedge clk); bit_xfer = 1'b0;
    endtask

    // Tick until an SOF is seen; returns the number of ticks used.
    task automatic ticks_to_sof(output int n);
        n = 0;
        do begin
            tick_once();
            n++;
        end while (!sof_pulse && n < 20000);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        read_reg(1'b0, d); check("R1 interval reset", d, 32'h0000_2EDF);
        read_reg(1'b1, d); check("R1 remaining reset", d, 32'h0);
        check("R1 frame reset", {16'h0, frame_num}, 32'h0);
        check("R1 budget reset", {17'h0, pkt_budget}, 32'h0);
        check("R1 empty reset", {31'h0, pkt_budget_empty}, 32'h1);
        check("R1 sof reset", {31'h0, sof_pulse}, 32'h0);
    endtask

    task automatic test_regs();
        logic [31:0] d;
        write_reg(1'b0, 32'hFFFF_FFFF);
        read_reg(1'b0, d); check("R2 reserved bits read zero", d, 32'hFFFF_3FFF);
        write_reg(1'b1, 32'hFFFF_FFFF);
        read_reg(1'b1, d); check("R3 remaining write ignored", d, 32'h0);
        write_reg(1'b0, 32'h0005_0003);
        read_reg(1'b0, d); check("R2 fields stored", d, 32'h0005_0003);
    endtask

    task automatic test_first_frame();
        logic [31:0] d;
        int n;
        tick_once();
        check("R5 sof on zero tick", {31'h0, sof_pulse}, 32'h1);
        read_reg(1'b1, d); check("R5 reload value", d, 32'h0000_0003);
        check("R8 frame after first sof", {16'h0, frame_num}, 32'h1);
        check("R9 budget loaded", {17'h0, pkt_budget}, 32'h5);
        @(negedge clk);
        check("R5 sof one clock", {31'h0, sof_pulse}, 32'h0);
        tick_once();
        read_reg(1'b1, d); check("R4 decrement", d, 32'h0000_0002);
        repeat (3) @(negedge clk);
        read_reg(1'b1, d); check("R4 hold without tick", d, 32'h0000_0002);
        ticks_to_sof(n);
        check("R6 ticks to next sof (partial frame)", n, 3);
        ticks_to_sof(n);
        check("R6 sof spacing interval+1", n, 4);
        check("R8 frame after third sof", {16'h0, frame_num}, 32'h3);
    endtask

    task automatic test_toggle_and_midframe();
        logic [31:0] d;
        int n;
        write_reg(1'b0, 32'h8005_0009);
        read_reg(1'b1, d); check("R11 count kept after write", d, 32'h0000_0003);
        tick_once();
        read_reg(1'b1, d); check("R11 old count keeps stepping", d, 32'h0000_0002);
        ticks_to_sof(n);
        check("R11 frame end not moved", n, 3);
        read_reg(1'b1, d); check("R7 toggle set at reload", d, 32'h8000_0009);
        write_reg(1'b0, 32'h0005_0009);
        read_reg(1'b1, d); check("R7 toggle not changed mid-frame", d, 32'h8000_0009);
        ticks_to_sof(n);
        check("R6 spacing with interval 9", n, 10);
        read_reg(1'b1, d); check("R7 toggle cleared at reload", d, 32'h0000_0009);
    endtask

    task automatic test_budget();
        check("R9 budget at frame start", {17'h0, pkt_budget}, 32'h5);
        xfer_once(); xfer_once();
        check("R10 budget steps", {17'h0, pkt_budget}, 32'h3);
        check("R10 not empty", {31'h0, pkt_budget_empty}, 32'h0);
        repeat (3) xfer_once();
        check("R10 budget reaches zero", {17'h0, pkt_budget}, 32'h0);
        check("R10 empty flag", {31'h0, pkt_budget_empty}, 32'h1);
        xfer_once();
        check("R10 saturates at zero", {17'h0, pkt_budget}, 32'h0);
    endtask

    task automatic test_wrap();
        int n;
        write_reg(1'b0, 32'h0000_0000);
        ticks_to_sof(n);
        check("R8 frame before wrap run", {16'h0, frame_num}, 32'h6);
        @(negedge clk); bit_tick = 1'b1;
        repeat (65536 - 6) @(negedge clk);
        bit_tick = 1'b0;
        check("R8 frame wraps to zero", {16'h0, frame_num}, 32'h0);
        check("R5 sof on every tick at interval 0", {31'h0, sof_pulse}, 32'h1);
        @(negedge clk);
        check("R5 sof drops after ticks stop", {31'h0, sof_pulse}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_regs();
        test_first_frame();
        test_toggle_and_midframe();
        test_budget();
        test_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule